// File: doc/BRIEF.md
# Converter Result Output Port

This block sits between a conversion engine and a host. Each time the engine strobes that a conversion has finished, the block takes the 16-bit result and presents it through a single output register. Static configuration inputs choose how the host reads that register. It can be read as a full 16-bit parallel word, as two byte-wide parallel reads, or as a serial stream. The serial stream runs either as master, with its own divided bit clock and a frame marker, or as slave, clocked by the host under a chip select.

The result can be coded as straight binary or as two's complement. Two's complement is formed by flipping the top bit of the input. Tri-state behaviour is modelled with explicit enable outputs, one per pin group. The pad ring merges each value with its enable.

All logic runs on one system clock, with a synchronous active-low reset. The external serial clock and chip select are brought into that clock domain through synchroniser stages before use.

Top module: `conv_result_port`

## Requirements
- R1: With `cfg_straight_i` high the captured word equals `result_i`; with it low the captured word is `result_i` with bit 15 inverted (e.g. 16'h8000 becomes 16'h0000, 16'h7FFF becomes 16'hFFFF).
- R2: In 16-bit parallel mode (`cfg_serial_i`=0, `cfg_byte_mode_i`=0) all 16 `bus_oe_o` bits are 1. `bus_o` carries the word as-is when `cfg_swap_i`=0. When `cfg_swap_i`=1, `bus_o` carries `{word[7:0], word[15:8]}`. `bus_o` updates at the clock edge that samples `done_i`.
- R3: In byte parallel mode (`cfg_serial_i`=0, `cfg_byte_mode_i`=1) `bus_oe_o` is 16'h00FF and the byte sits on `bus_o[7:0]`. After a capture the first byte is bits [15:8] of the lane-swapped word of R2. Each `rd_stb_i` pulse toggles to the other byte.
- R4: With `cfg_serial_i`=1, `bus_oe_o` is all zero.
- R5: In serial master mode (`cfg_serial_i`=1, `cfg_slave_i`=0) a capture starts a frame in the same edge. Bit 15-b of the word is on `sdout_o` throughout SCLK period b (b=0..15), MSB first. The data changes only after the internal clock's falling half.
- R6: In master mode the internal clock (before inversion) starts low and spends 2^`cfg_div_i` system cycles in each half period. A frame therefore lasts 32·2^`cfg_div_i` cycles.
- R7: `sync_o` is at its active level for the entire master frame and inactive otherwise. The active level is high when `cfg_sync_inv_i`=0 and low when it is 1. `sync_oe_o` and `sclk_oe_o` are 1 only in master mode.
- R8: `cfg_sclk_inv_i`=1 inverts `sclk_o` in master mode. In slave mode it inverts the sense of `sclk_i`, so data advances on the rising edge of the raw `sclk_i`.
- R9: In slave mode `sdout_oe_o` is 0 while the synchronised `cs_n_i` is high. With it low, `sdout_o` shows the MSB first and moves to the next bit after each falling edge of the effective clock. Raising `cs_n_i` resets the bit pointer, so the next selection restarts at the MSB.
- R10: A `done_i` that arrives during a serial frame does not disturb it. A frame is either a master frame, or a slave selection with `cs_n_i` low. The held result is loaded once the frame ends; in master mode it then starts a new frame one cycle after the previous one ended.
- R11: After reset the output word is 0, no frame is running, and `sync_o` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| done_i | input | 1 | Conversion-finished strobe, one cycle |
| result_i | input | DATA_W | Raw straight-binary conversion result |
| cfg_serial_i | input | 1 | 1 = serial port, 0 = parallel bus |
| cfg_byte_mode_i | input | 1 | Parallel: 1 = two byte reads, 0 = full word |
| cfg_swap_i | input | 1 | Exchange the two byte lanes |
| cfg_straight_i | input | 1 | 1 = straight binary, 0 = two's complement |
| cfg_slave_i | input | 1 | Serial: 1 = host clock, 0 = internal clock |
| cfg_sync_inv_i | input | 1 | 1 = active-low frame marker |
| cfg_sclk_inv_i | input | 1 | Invert serial clock sense |
| cfg_div_i | input | DIV_W | Master clock divide select (ratio 2^value) |
| rd_stb_i | input | 1 | Byte-mode read advance pulse |
| cs_n_i | input | 1 | Slave chip select, active low |
| sclk_i | input | 1 | Slave serial clock from host |
| bus_o | output | DATA_W | Parallel data |
| bus_oe_o | output | DATA_W | Per-pin drive enable of `bus_o` |
| sdout_o | output | 1 | Serial data |
| sdout_oe_o | output | 1 | Drive enable of `sdout_o` |
| sclk_o | output | 1 | Master serial clock |
| sclk_oe_o | output | 1 | Drive enable of `sclk_o` |
| sync_o | output | 1 | Master frame marker |
| sync_oe_o | output | 1 | Drive enable of `sync_o` |

## Verification
The bench checks master frames cycle by cycle at every divide setting, with both polarities of the clock and the frame marker. An off-by-one divider or a bit advanced on the wrong half period would show up there as a misplaced bit or a stretched frame. A result strobed in the middle of a master frame and in the middle of a slave selection catches a design that overwrites the word being shifted. It also checks that the held value appears in the following frame, which exposes a design that drops it. Slave selections are cut short and then restarted, which exposes a bit pointer that does not reset. Byte mode is read in both lane orders, and the two's-complement corners 16'h8000 and 16'h7FFF are applied to catch a flip of the wrong bit.

// File: rtl/crp_pkg.sv
// Package: shared types for the converter result output port.
// Assumes configuration inputs are static while a transfer is in progress.
package crp_pkg;

    typedef enum logic [1:0] {
        MODE_WORD   = 2'd0,
        MODE_BYTE   = 2'd1,
        MODE_MASTER = 2'd2,
        MODE_SLAVE  = 2'd3
    } port_mode_e;

    // Collapse the configuration pins into one operating mode.
    function automatic port_mode_e decode_mode(input logic serial,
                                               input logic byte_mode,
                                               input logic slave);
        if (serial)
            return slave ? MODE_SLAVE : MODE_MASTER;
        return byte_mode ? MODE_BYTE : MODE_WORD;
    endfunction

endpackage

// File: rtl/crp_coder.sv
// Module: crp_coder
// Applies the output coding to a raw straight-binary result.
// Assumes the raw result is straight binary; two's complement is the MSB flipped.
module crp_coder #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic              straight_i,
    output logic [DATA_W-1:0] coded_o
);

    localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    // Flip the top bit unless straight binary is selected.
    always_comb begin
        coded_o = straight_i ? raw_i : (raw_i ^ MSB_MASK);
    end

endmodule

// File: rtl/crp_par_lanes.sv
// Module: crp_par_lanes
// Drives the parallel bus: full word or byte-at-a-time, with lane swap.
// Assumes DATA_W is even; the bus is released entirely in serial modes.
module crp_par_lanes #(
    parameter int DATA_W = 16
) (
    input  crp_pkg::port_mode_e mode_i,
    input  logic [DATA_W-1:0]   word_i,
    input  logic                swap_i,
    input  logic                byte_sel_i,
    output logic [DATA_W-1:0]   bus_o,
    output logic [DATA_W-1:0]   bus_oe_o
);
    import crp_pkg::*;

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] lane_word;
    logic [HALF_W-1:0] cur_byte;

    // Exchange the byte lanes when requested.
    always_comb begin
        lane_word = swap_i ? {word_i[HALF_W-1:0], word_i[DATA_W-1:HALF_W]} : word_i;
        cur_byte  = byte_sel_i ? lane_word[HALF_W-1:0] : lane_word[DATA_W-1:HALF_W];
    end

    // Select the bus content and enables for the current mode.
    always_comb begin
        unique case (mode_i)
            MODE_WORD: begin
                bus_o    = lane_word;
                bus_oe_o = '1;
            end
            MODE_BYTE: begin
                bus_o    = {{HALF_W{1'b0}}, cur_byte};
                bus_oe_o = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            end
            default: begin
                bus_o    = '0;
                bus_oe_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/crp_master.sv
// Module: crp_master
// Serial master: divided bit clock, MSB-first shift and frame tracking.
// Assumes word_i is stable while frame_o is high and start_i only pulses when idle.
module crp_master #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              frame_o,
    output logic              sclk_o,
    output logic              sdout_o
);

    localparam int BW      = $clog2(DATA_W);
    localparam int HCW_RAW = (1 << DIV_W) - 1;
    localparam int HCW     = (HCW_RAW > 1) ? HCW_RAW : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    logic [HCW-1:0] half_cnt;
    logic [HCW-1:0] half_lim;
    logic [BW-1:0]  bit_q;
    logic           sclk_q;
    logic           frame_q;

    // Last count value of a half period, 2^div cycles long.
    always_comb begin
        half_lim = HCW'((32'd1 << div_i) - 32'd1);
    end

    // Advance the divider, toggle the clock and step through the bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q  <= 1'b0;
            half_cnt <= '0;
            sclk_q   <= 1'b0;
            bit_q    <= '0;
        end else if (start_i) begin
            frame_q  <= 1'b1;
            half_cnt <= '0;
            sclk_q   <= 1'b0;
            bit_q    <= '0;
        end else if (frame_q) begin
            if (half_cnt == half_lim) begin
                half_cnt <= '0;
                sclk_q   <= ~sclk_q;
                if (sclk_q) begin
                    if (bit_q == LAST_BIT)
                        frame_q <= 1'b0;
                    else
                        bit_q <= bit_q + 1'b1;
                end
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    // Present the current bit while a frame runs.
    always_comb begin
        frame_o = frame_q;
        sclk_o  = sclk_q;
        sdout_o = frame_q ? word_i[LAST_BIT - bit_q] : 1'b0;
    end

endmodule

// File: rtl/crp_slave.sv
// Module: crp_slave
// Serial slave: synchronises host clock and select, walks an MSB-first pointer.
// Assumes the host clock half period exceeds SYNC_STAGES+1 system cycles.
module crp_slave #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sclk_inv_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              selected_o,
    output logic              sdout_o
);

    localparam int BW = $clog2(DATA_W);
    localparam int PW = BW + 1;
    localparam logic [PW-1:0] END_PTR  = PW'(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    logic [SYNC_STAGES-1:0] cs_pipe;
    logic [SYNC_STAGES-1:0] ck_pipe;
    logic                   cs_s;
    logic                   ck_eff;
    logic                   ck_prev;
    logic                   ck_fall;
    logic [PW-1:0]          ptr_q;

    // Synchroniser chains for the host select and clock.
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cs_pipe <= '1;
                    ck_pipe <= '0;
                end else begin
                    cs_pipe <= cs_n_i;
                    ck_pipe <= sclk_i;
                end
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cs_pipe <= '1;
                    ck_pipe <= '0;
                end else begin
                    cs_pipe <= {cs_pipe[SYNC_STAGES-2:0], cs_n_i};
                    ck_pipe <= {ck_pipe[SYNC_STAGES-2:0], sclk_i};
                end
            end
        end
    endgenerate

    // Effective clock sense and its falling edge.
    always_comb begin
        cs_s    = cs_pipe[SYNC_STAGES-1];
        ck_eff  = ck_pipe[SYNC_STAGES-1] ^ sclk_inv_i;
        ck_fall = ck_prev & ~ck_eff;
    end

    // Remember the previous effective clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) ck_prev <= 1'b0;
        else        ck_prev <= ck_eff;
    end

    // Bit pointer: cleared while deselected, stepped on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (cs_s)
            ptr_q <= '0;
        else if (ck_fall && ptr_q != END_PTR)
            ptr_q <= ptr_q + 1'b1;
    end

    // Output the pointed bit, zero once the word is exhausted.
    always_comb begin
        selected_o = ~cs_s;
        sdout_o    = (ptr_q < END_PTR) ? word_i[LAST_BIT - ptr_q[BW-1:0]] : 1'b0;
    end

endmodule

// File: rtl/conv_result_port.sv
// Module: conv_result_port (top)
// Holds one coded conversion result and presents it on a parallel bus or a
// master/slave serial port chosen by static configuration inputs.
// Assumes done_i is a one-cycle strobe and configuration changes only when idle.
module conv_result_port #(
    parameter int DATA_W      = 16,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              cfg_serial_i,
    input  logic              cfg_byte_mode_i,
    input  logic              cfg_swap_i,
    input  logic              cfg_straight_i,
    input  logic              cfg_slave_i,
    input  logic              cfg_sync_inv_i,
    input  logic              cfg_sclk_inv_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic              rd_stb_i,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    output logic [DATA_W-1:0] bus_o,
    output logic [DATA_W-1:0] bus_oe_o,
    output logic              sdout_o,
    output logic              sdout_oe_o,
    output logic              sclk_o,
    output logic              sclk_oe_o,
    output logic              sync_o,
    output logic              sync_oe_o
);
    import crp_pkg::*;

    port_mode_e        mode;
    logic [DATA_W-1:0] coded;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] pend_word_q;
    logic              pend_q;
    logic              byte_sel_q;
    logic              busy;
    logic              load;
    logic              m_start;
    logic              m_frame;
    logic              m_sclk;
    logic              m_sdout;
    logic              s_sel;
    logic              s_sdout;
    logic              is_master;
    logic              is_slave;

    // Operating mode from the configuration pins.
    always_comb begin
        mode      = decode_mode(cfg_serial_i, cfg_byte_mode_i, cfg_slave_i);
        is_master = (mode == MODE_MASTER);
        is_slave  = (mode == MODE_SLAVE);
    end

    crp_coder #(.DATA_W(DATA_W)) u_coder (
        .raw_i      (result_i),
        .straight_i (cfg_straight_i),
        .coded_o    (coded)
    );

    // A frame in progress blocks updates of the output word.
    always_comb begin
        busy    = (is_master && m_frame) || (is_slave && s_sel);
        load    = !busy && (done_i || pend_q);
        m_start = load && is_master;
    end

    // Output word register with a one-deep hold for captures during a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q      <= '0;
            pend_word_q <= '0;
            pend_q      <= 1'b0;
        end else if (done_i && busy) begin
            pend_word_q <= coded;
            pend_q      <= 1'b1;
        end else if (done_i) begin
            word_q <= coded;
            pend_q <= 1'b0;
        end else if (pend_q && !busy) begin
            word_q <= pend_word_q;
            pend_q <= 1'b0;
        end
    end

    // Byte-mode read pointer: first byte after a load, toggles per read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            byte_sel_q <= 1'b0;
        else if (load)
            byte_sel_q <= 1'b0;
        else if (rd_stb_i && mode == MODE_BYTE)
            byte_sel_q <= ~byte_sel_q;
    end

    crp_par_lanes #(.DATA_W(DATA_W)) u_lanes (
        .mode_i     (mode),
        .word_i     (word_q),
        .swap_i     (cfg_swap_i),
        .byte_sel_i (byte_sel_q),
        .bus_o      (bus_o),
        .bus_oe_o   (bus_oe_o)
    );

    crp_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (m_start),
        .div_i   (cfg_div_i),
        .word_i  (word_q),
        .frame_o (m_frame),
        .sclk_o  (m_sclk),
        .sdout_o (m_sdout)
    );

    crp_slave #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n_i),
        .sclk_i     (sclk_i),
        .sclk_inv_i (cfg_sclk_inv_i),
        .word_i     (word_q),
        .selected_o (s_sel),
        .sdout_o    (s_sdout)
    );

    // Serial pin values and drive enables per mode.
    always_comb begin
        sclk_oe_o  = is_master;
        sync_oe_o  = is_master;
        sclk_o     = is_master ? (m_sclk ^ cfg_sclk_inv_i) : 1'b0;
        sync_o     = is_master ? (m_frame ^ cfg_sync_inv_i) : 1'b0;
        sdout_o    = is_master ? m_sdout : (is_slave ? s_sdout : 1'b0);
        sdout_oe_o = is_master || (is_slave && s_sel);
    end

endmodule

// File: rtl/crp_checks.sv
// Module: crp_checks
// Protocol checks on the port pins of conv_result_port, attached by bind.
module crp_checks #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_serial_i,
    input logic              cfg_byte_mode_i,
    input logic              cfg_slave_i,
    input logic              cfg_sync_inv_i,
    input logic              cfg_sclk_inv_i,
    input logic              cs_n_i,
    input logic [DATA_W-1:0] bus_oe_o,
    input logic              sdout_o,
    input logic              sdout_oe_o,
    input logic              sclk_o,
    input logic              sync_o
);

    // R4
    serial_bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_serial_i |-> (bus_oe_o == '0));

    // R3
    byte_lane_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_serial_i && cfg_byte_mode_i) |-> (bus_oe_o[DATA_W-1:DATA_W/2] == '0));

    // R9
    slave_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_serial_i && cfg_slave_i && cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2)
         && $past(cs_n_i, 3)) |-> !sdout_oe_o);

    // R7
    sclk_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_serial_i && !cfg_slave_i && $stable(cfg_sclk_inv_i) && $stable(cfg_sync_inv_i)
         && $stable(cfg_serial_i) && $stable(cfg_slave_i) && (sclk_o != $past(sclk_o)))
        |-> ($past(sync_o) != cfg_sync_inv_i));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_serial_i && !cfg_slave_i && $stable(cfg_sclk_inv_i) && $stable(cfg_sync_inv_i)
         && $stable(cfg_serial_i) && $stable(cfg_slave_i)
         && ($past(sync_o) != cfg_sync_inv_i) && (sync_o != cfg_sync_inv_i) && $stable(sclk_o))
        |-> $stable(sdout_o));

endmodule

bind conv_result_port crp_checks #(.DATA_W(DATA_W)) u_crp_checks (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_serial_i    (cfg_serial_i),
    .cfg_byte_mode_i (cfg_byte_mode_i),
    .cfg_slave_i     (cfg_slave_i),
    .cfg_sync_inv_i  (cfg_sync_inv_i),
    .cfg_sclk_inv_i  (cfg_sclk_inv_i),
    .cs_n_i          (cs_n_i),
    .bus_oe_o        (bus_oe_o),
    .sdout_o         (sdout_o),
    .sdout_oe_o      (sdout_oe_o),
    .sclk_o          (sclk_o),
    .sync_o          (sync_o)
);

// File: tb/conv_result_port_test.sv
// Bench for conv_result_port: seeded random plus directed corners.
module conv_result_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_i = 1'b0;
    logic [15:0] result_i = '0;
    logic        cfg_serial_i = 1'b0;
    logic        cfg_byte_mode_i = 1'b0;
    logic        cfg_swap_i = 1'b0;
    logic        cfg_straight_i = 1'b1;
    logic        cfg_slave_i = 1'b0;
    logic        cfg_sync_inv_i = 1'b0;
    logic        cfg_sclk_inv_i = 1'b0;
    logic [1:0]  cfg_div_i = '0;
    logic        rd_stb_i = 1'b0;
    logic        cs_n_i = 1'b1;
    logic        sclk_i = 1'b0;
    logic [15:0] bus_o, bus_oe_o;
    logic        sdout_o, sdout_oe_o, sclk_o, sclk_oe_o, sync_o, sync_oe_o;

    int vectors = 0;
    int errors  = 0;
    bit ended   = 1'b0;

    always #2.5 clk = ~clk;

    conv_result_port uut (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .result_i(result_i),
        .cfg_serial_i(cfg_serial_i), .cfg_byte_mode_i(cfg_byte_mode_i),
        .cfg_swap_i(cfg_swap_i), .cfg_straight_i(cfg_straight_i),
        .cfg_slave_i(cfg_slave_i), .cfg_sync_inv_i(cfg_sync_inv_i),
        .cfg_sclk_inv_i(cfg_sclk_inv_i), .cfg_div_i(cfg_div_i),
        .rd_stb_i(rd_stb_i), .cs_n_i(cs_n_i), .sclk_i(sclk_i),
        .bus_o(bus_o), .bus_oe_o(bus_oe_o), .sdout_o(sdout_o),
        .sdout_oe_o(sdout_oe_o), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
        .sync_o(sync_o), .sync_oe_o(sync_oe_o)
    );

    function automatic logic [15:0] exp_code(input logic [15:0] raw, input logic straight);
        return straight ? raw : {~raw[15], raw[14:0]};
    endfunction

    function automatic logic [15:0] exp_lanes(input logic [15:0] w, input logic swap);
        return swap ? {w[7:0], w[15:8]} : w;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // Pulse done with a value; returns at the negedge after the capturing edge.
    task automatic capture(input logic [15:0] val);
        result_i = val;
        done_i   = 1'b1;
        @(negedge clk);
        done_i   = 1'b0;
    endtask

    // Check a master frame from state k=0 to its end; optionally strobe a new result at k=5.
    task automatic master_frame(input logic [15:0] w, input int div, input bit inject,
                                input logic [15:0] inj_val);
        int h;
        h = 1 << div;
        for (int k = 0; k <= 32 * h; k++) begin
            if (k < 32 * h) begin
                check("R7 sync active", {15'd0, sync_o}, {15'd0, ~cfg_sync_inv_i});
                check("R6/R8 sclk level", {15'd0, sclk_o},
                      {15'd0, (((k / h) % 2) == 1) ^ cfg_sclk_inv_i});
                check("R5 sdout bit", {15'd0, sdout_o}, {15'd0, w[15 - k / (2 * h)]});
            end else begin
                check("R7 sync idle at end", {15'd0, sync_o}, {15'd0, cfg_sync_inv_i});
            end
            if (inject && k == 5) begin
                result_i = inj_val;
                done_i   = 1'b1;
            end
            if (inject && k == 6) done_i = 1'b0;
            if (k < 32 * h) @(negedge clk);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Slave: drive one effective-clock period (rise then fall).
    task automatic slave_pulse();
        sclk_i = 1'b1 ^ cfg_sclk_inv_i;
        wait_cycles(4);
        sclk_i = 1'b0 ^ cfg_sclk_inv_i;
        wait_cycles(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] a, b, w;
        bit sw, st, bm;
        void'($urandom(32'd2024));

        // R11: reset state
        wait_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 word after reset", bus_o, 16'h0000);
        check("R2 full enables", bus_oe_o, 16'hFFFF);
        cfg_serial_i = 1'b1;
        @(negedge clk);
        check("R11 sync inactive", {15'd0, sync_o}, 16'd0);
        check("R4 bus released", bus_oe_o, 16'h0000);
        cfg_serial_i = 1'b0;
        @(negedge clk);

        // R1: coding corners
        cfg_straight_i = 1'b0;
        capture(16'h8000);
        check("R1 code 8000", bus_o, 16'h0000);
        capture(16'h7FFF);
        check("R1 code 7FFF", bus_o, 16'hFFFF);
        cfg_straight_i = 1'b1;
        capture(16'h7FFF);
        check("R1 straight", bus_o, 16'h7FFF);

        // R2/R3: random parallel trials
        for (int t = 0; t < 60; t++) begin
            a  = 16'($urandom);
            sw = 1'($urandom);
            st = 1'($urandom);
            bm = 1'($urandom);
            cfg_swap_i = sw;
            cfg_straight_i = st;
            cfg_byte_mode_i = bm;
            capture(a);
            w = exp_lanes(exp_code(a, st), sw);
            if (!bm) begin
                check("R2 word lanes", bus_o, w);
                check("R2 enables", bus_oe_o, 16'hFFFF);
            end else begin
                check("R3 first byte", bus_o, {8'h00, w[15:8]});
                check("R3 enables", bus_oe_o, 16'h00FF);
                rd_stb_i = 1'b1;
                @(negedge clk);
                rd_stb_i = 1'b0;
                check("R3 second byte", bus_o, {8'h00, w[7:0]});
                rd_stb_i = 1'b1;
                @(negedge clk);
                rd_stb_i = 1'b0;
                check("R3 back to first", bus_o, {8'h00, w[15:8]});
            end
        end
        cfg_byte_mode_i = 1'b0;
        cfg_swap_i = 1'b0;
        cfg_straight_i = 1'b1;

        // R5/R6/R7/R8: master frames for every divide and polarity
        cfg_serial_i = 1'b1;
        cfg_slave_i  = 1'b0;
        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 2; p++) begin
                cfg_div_i      = 2'(d);
                cfg_sync_inv_i = p[0];
                cfg_sclk_inv_i = 1'($urandom);
                @(negedge clk);
                check("R7 master enables", {14'd0, sclk_oe_o, sync_oe_o}, 16'd3);
                check("R4 bus released master", bus_oe_o, 16'h0000);
                a = 16'($urandom);
                capture(a);
                master_frame(a, d, 1'b0, 16'h0);
                @(negedge clk);
            end
        end

        // R10: capture during a master frame is deferred to the next frame
        cfg_div_i = 2'd0;
        cfg_sync_inv_i = 1'b0;
        cfg_sclk_inv_i = 1'b0;
        a = 16'hA5C3;
        b = 16'h3C5A;
        capture(a);
        master_frame(a, 0, 1'b1, b);
        @(negedge clk);
        check("R10 deferred frame start", {15'd0, sync_o}, 16'd1);
        master_frame(b, 0, 1'b0, 16'h0);
        wait_cycles(2);

        // R8/R9: slave mode with both clock senses
        cfg_slave_i = 1'b1;
        for (int p = 0; p < 2; p++) begin
            cfg_sclk_inv_i = p[0];
            sclk_i = cfg_sclk_inv_i;
            a = 16'($urandom);
            capture(a);
            wait_cycles(3);
            check("R9 released while deselected", {15'd0, sdout_oe_o}, 16'd0);
            check("R7 no master drive in slave", {14'd0, sclk_oe_o, sync_oe_o}, 16'd0);
            cs_n_i = 1'b0;
            wait_cycles(3);
            check("R9 driven when selected", {15'd0, sdout_oe_o}, 16'd1);
            for (int i = 0; i < 16; i++) begin
                check("R8/R9 slave bit", {15'd0, sdout_o}, {15'd0, a[15 - i]});
                slave_pulse();
            end
            // abort part-way and reselect: pointer restarts at MSB
            cs_n_i = 1'b1;
            wait_cycles(4);
            cs_n_i = 1'b0;
            wait_cycles(3);
            slave_pulse();
            slave_pulse();
            check("R9 third bit", {15'd0, sdout_o}, {15'd0, a[13]});
            cs_n_i = 1'b1;
            wait_cycles(4);
            check("R9 released after deselect", {15'd0, sdout_oe_o}, 16'd0);
            cs_n_i = 1'b0;
            wait_cycles(3);
            check("R9 restart at MSB", {15'd0, sdout_o}, {15'd0, a[15]});
            cs_n_i = 1'b1;
            wait_cycles(4);
        end

        // R10: capture during a slave selection is held until deselect
        cfg_sclk_inv_i = 1'b0;
        sclk_i = 1'b0;
        a = 16'hF00F;
        b = 16'h0FF0;
        capture(a);
        cs_n_i = 1'b0;
        wait_cycles(3);
        slave_pulse();
        capture(b);
        wait_cycles(1);
        for (int i = 1; i < 6; i++) begin
            check("R10 slave frame undisturbed", {15'd0, sdout_o}, {15'd0, a[15 - i]});
            slave_pulse();
        end
        cs_n_i = 1'b1;
        wait_cycles(4);
        cs_n_i = 1'b0;
        wait_cycles(3);
        for (int i = 0; i < 4; i++) begin
            check("R10 held value loaded", {15'd0, sdout_o}, {15'd0, b[15 - i]});
            slave_pulse();
        end
        cs_n_i = 1'b1;
        wait_cycles(4);

        finish_run();
    end

endmodule